// File: doc/BRIEF.md
# External Memory Bus Controller

This controller sits between a microcontroller core and a set of general-purpose port pins. It turns the core's external data-space loads and stores into strobed bus cycles. The core presents a request with a 16-bit address, a write byte and a direction flag. The controller then does one of two things:

- For an on-chip address, it raises a one-cycle internal-select pulse.
- For an off-chip address, it takes over the pins and runs one bus transaction. It returns read data with a one-cycle done pulse, then hands the pins back.

While no off-chip access is running, every pin shows its port latch value. The pads receive only a value and, for the data lines, an output enable. The per-pin drive type is set elsewhere.

Four inputs set up a transaction, and all four are sampled when the request is accepted:

- **Address wiring.** Multiplexed mode puts the low address byte and the data byte on the same eight pins and separates them with an address latch enable pulse. Non-multiplexed mode uses separate low-address pins.
- **Memory map.** A two-bit code decides which addresses go on-chip.
- **Strobe width.** A three-bit code sets how long the read or write strobe stays low.
- **Bank byte.** An eight-bit value that can supply the upper address byte.

Top module: `emi_ctrl`

## Requirements
- R1: While reset is high and afterwards with no off-chip access running, every pad output equals its port latch input and `pad_dat_oe` equals `lat_dat_oe`. Also, after reset, `rsp_done`=0, `int_sel`=0, `req_ready`=1 and `rsp_rdata`=0.
- R2: `cfg_map` selects where each address goes:
  - 0: every access is on-chip.
  - 3: every access is off-chip.
  - 1 and 2: addresses below 0x1000 are on-chip and addresses of 0x1000 or above are off-chip.

  An accepted on-chip request raises `int_sel` for exactly the one cycle after acceptance. It touches no pin and gives no `rsp_done`.
- R3: Multiplexed access (`cfg_mux`=1), counting from the cycle after acceptance:
  - 1 cycle with `pad_ale_o` high;
  - 1 cycle with `pad_ale_o` low;
  - W = `cfg_width`+1 strobe cycles;
  - 1 hold cycle.

  `rsp_done` is high for the single cycle that follows the hold cycle.
- R4: Non-multiplexed access (`cfg_mux`=0): 1 setup cycle, then W strobe cycles, then 1 hold cycle, then a one-cycle `rsp_done`. Throughout, `pad_ale_o` follows `lat_ale`.
- R5: Data pins during an access:
  - In multiplexed mode, both address cycles drive `req_addr[7:0]` with `pad_dat_oe`=1.
  - After that, a write drives the write byte with `pad_dat_oe`=1. In non-multiplexed mode this covers setup, strobe and hold.
  - A read holds `pad_dat_oe`=0 after the address cycles.
- R6: Low address pins: in non-multiplexed mode `pad_alo_o` carries `req_addr[7:0]` for the whole access. In multiplexed mode they follow `lat_alo`.
- R7: Upper address pins during an access:
  - map 3: `pad_ahi_o` = `req_addr[15:8]`;
  - map 2: `pad_ahi_o` = `cfg_bank`;
  - map 1: `pad_ahi_o` follows `lat_ahi`.
- R8: Read data is taken from `pad_dat_i` on the last strobe cycle only. `rsp_rdata` keeps that value through later writes and on-chip accesses.
- R9: `req_ready` is low from the cycle after an off-chip acceptance until the done cycle. A request still held valid is accepted at the end of the done cycle, so its first bus cycle follows at once.
- R10: For the whole access, the controller owns both strobe pins: `pad_rd_n_o` goes low only in strobe cycles of a read, and `pad_wr_n_o` only in strobe cycles of a write. In the done cycle all pins show the latches again.
- R11: Changes to `cfg_mux`, `cfg_width`, `cfg_map` or `cfg_bank` after acceptance do not affect the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mux | input | 1 | 1 = multiplexed address/data, 0 = separate pins |
| cfg_map | input | 2 | Memory-map code (0 on-chip, 1 split, 2 split with bank, 3 off-chip) |
| cfg_width | input | 3 | Strobe low time minus one, in cycles |
| cfg_bank | input | 8 | Upper address byte for map code 2 |
| req_valid | input | 1 | Access request |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | Controller can accept a request |
| rsp_done | output | 1 | One-cycle pulse at the end of an off-chip access |
| rsp_rdata | output | 8 | Last byte read from the bus |
| int_sel | output | 1 | One-cycle pulse for an on-chip access |
| lat_ale | input | 1 | Port latch value for the latch-enable pin |
| lat_rd_n | input | 1 | Port latch value for the read strobe pin |
| lat_wr_n | input | 1 | Port latch value for the write strobe pin |
| lat_ahi | input | 8 | Port latch values for the upper address pins |
| lat_alo | input | 8 | Port latch values for the low address pins |
| lat_dat | input | 8 | Port latch values for the data pins |
| lat_dat_oe | input | 1 | Port output enable for the data pins |
| pad_ale_o | output | 1 | Latch-enable pin value |
| pad_rd_n_o | output | 1 | Read strobe pin value (active low) |
| pad_wr_n_o | output | 1 | Write strobe pin value (active low) |
| pad_ahi_o | output | 8 | Upper address pin values |
| pad_alo_o | output | 8 | Low address pin values |
| pad_dat_o | output | 8 | Data pin values |
| pad_dat_oe | output | 1 | Data pin output enable |
| pad_dat_i | input | 8 | Data pin input values |

## Verification
Two events can fall in the same cycle: the done pulse that ends one off-chip access, and the acceptance of the next request. The bench holds a second request valid while the first access is still running. It then requires three things:
- `req_ready` stays low and the data pins still carry the first address during the first access;
- `req_ready` rises together with `rsp_done`;
- the very next cycle is the second access's latch-enable cycle, carrying the second address.

A second case overlaps configuration changes with a running access. The bench then checks that strobe timing and pin ownership still follow the values sampled at acceptance.

// File: rtl/emi_pkg.sv
package emi_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;
    parameter int STRB_W = 3;
    localparam int HI_W  = ADDR_W - DATA_W;

    typedef enum logic [1:0] {
        MAP_ONCHIP  = 2'b00,
        MAP_SPLIT   = 2'b01,
        MAP_BANKED  = 2'b10,
        MAP_OFFCHIP = 2'b11
    } map_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE_HI,
        PH_ALE_LO,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
        logic              mux;
        map_e              map;
        logic [STRB_W-1:0] width;
        logic [HI_W-1:0]   bank;
    } txn_t;

    typedef struct packed {
        logic              ale;
        logic              rd_n;
        logic              wr_n;
        logic [HI_W-1:0]   ahi;
        logic [DATA_W-1:0] alo;
        logic [DATA_W-1:0] dat;
        logic              dat_oe;
    } pins_t;

    function automatic logic is_offchip(map_e m, logic [ADDR_W-1:0] a,
                                        logic [ADDR_W-1:0] base);
        logic r;
        case (m)
            MAP_ONCHIP:  r = 1'b0;
            MAP_OFFCHIP: r = 1'b1;
            default:     r = (a >= base);
        endcase
        return r;
    endfunction
endpackage

// File: rtl/emi_decode.sv
module emi_decode
    import emi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SPLIT_BASE = 16'h1000
) (
    input  map_e              map,
    input  logic [ADDR_W-1:0] addr,
    output logic              offchip
);
    always_comb offchip = is_offchip(map, addr, SPLIT_BASE);
endmodule

// File: rtl/emi_seq.sv
module emi_seq
    import emi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_we,
    input  logic              cfg_mux,
    input  map_e              cfg_map,
    input  logic [STRB_W-1:0] cfg_width,
    input  logic [HI_W-1:0]   cfg_bank,
    input  logic              offchip,
    input  logic [DATA_W-1:0] pad_dat_i,
    output logic              req_ready,
    output phase_e            phase,
    output txn_t              txn,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              int_sel
);
    logic [STRB_W-1:0] cnt;
    logic              accept;

    always_comb begin
        req_ready = (phase == PH_IDLE);
        accept    = req_valid && req_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            txn       <= '0;
            cnt       <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
            int_sel   <= 1'b0;
        end else begin
            rsp_done <= 1'b0;
            int_sel  <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        if (offchip) begin
                            txn.addr  <= req_addr;
                            txn.wdata <= req_wdata;
                            txn.we    <= req_we;
                            txn.mux   <= cfg_mux;
                            txn.map   <= cfg_map;
                            txn.width <= cfg_width;
                            txn.bank  <= cfg_bank;
                            phase     <= cfg_mux ? PH_ALE_HI : PH_SETUP;
                        end else begin
                            int_sel <= 1'b1;
                        end
                    end
                end
                PH_ALE_HI: phase <= PH_ALE_LO;
                PH_ALE_LO: begin
                    phase <= PH_STROBE;
                    cnt   <= '0;
                end
                PH_SETUP: begin
                    phase <= PH_STROBE;
                    cnt   <= '0;
                end
                PH_STROBE: begin
                    if (cnt == txn.width) begin
                        phase <= PH_HOLD;
                        if (!txn.we) rsp_rdata <= pad_dat_i;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    phase    <= PH_IDLE;
                    rsp_done <= 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/emi_padmux.sv
module emi_padmux
    import emi_pkg::*;
(
    input  phase_e phase,
    input  txn_t   txn,
    input  pins_t  lat,
    output pins_t  pad
);
    logic own;
    logic addr_ph;

    always_comb begin
        own     = (phase != PH_IDLE);
        addr_ph = (phase == PH_ALE_HI) || (phase == PH_ALE_LO);
        pad     = lat;
        if (own) begin
            pad.rd_n = !((phase == PH_STROBE) && !txn.we);
            pad.wr_n = !((phase == PH_STROBE) && txn.we);
            if (txn.mux) pad.ale = (phase == PH_ALE_HI);
            else         pad.alo = txn.addr[DATA_W-1:0];
            case (txn.map)
                MAP_OFFCHIP: pad.ahi = txn.addr[ADDR_W-1:DATA_W];
                MAP_BANKED:  pad.ahi = txn.bank;
                default:     pad.ahi = lat.ahi;
            endcase
            if (txn.mux && addr_ph) begin
                pad.dat    = txn.addr[DATA_W-1:0];
                pad.dat_oe = 1'b1;
            end else if (txn.we) begin
                pad.dat    = txn.wdata;
                pad.dat_oe = 1'b1;
            end else begin
                pad.dat_oe = 1'b0;
            end
        end
    end
endmodule

// File: rtl/emi_ctrl.sv
module emi_ctrl
    import emi_pkg::*;
#(
    parameter logic [ADDR_W-1:0] SPLIT_BASE = 16'h1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mux,
    input  logic [1:0]        cfg_map,
    input  logic [STRB_W-1:0] cfg_width,
    input  logic [HI_W-1:0]   cfg_bank,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_we,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              int_sel,
    input  logic              lat_ale,
    input  logic              lat_rd_n,
    input  logic              lat_wr_n,
    input  logic [HI_W-1:0]   lat_ahi,
    input  logic [DATA_W-1:0] lat_alo,
    input  logic [DATA_W-1:0] lat_dat,
    input  logic              lat_dat_oe,
    output logic              pad_ale_o,
    output logic              pad_rd_n_o,
    output logic              pad_wr_n_o,
    output logic [HI_W-1:0]   pad_ahi_o,
    output logic [DATA_W-1:0] pad_alo_o,
    output logic [DATA_W-1:0] pad_dat_o,
    output logic              pad_dat_oe,
    input  logic [DATA_W-1:0] pad_dat_i
);
    map_e   map_sel;
    logic   offchip;
    phase_e phase;
    txn_t   txn;
    pins_t  lat_pins;
    pins_t  pad_pins;
    logic   seq_busy;
    logic   cur_mux;

    always_comb begin
        map_sel  = map_e'(cfg_map);
        seq_busy = (phase != PH_IDLE);
        cur_mux  = txn.mux;
        lat_pins = '{ale: lat_ale, rd_n: lat_rd_n, wr_n: lat_wr_n, ahi: lat_ahi,
                     alo: lat_alo, dat: lat_dat, dat_oe: lat_dat_oe};
        pad_ale_o  = pad_pins.ale;
        pad_rd_n_o = pad_pins.rd_n;
        pad_wr_n_o = pad_pins.wr_n;
        pad_ahi_o  = pad_pins.ahi;
        pad_alo_o  = pad_pins.alo;
        pad_dat_o  = pad_pins.dat;
        pad_dat_oe = pad_pins.dat_oe;
    end

    emi_decode #(.SPLIT_BASE(SPLIT_BASE)) u_dec (
        .map     (map_sel),
        .addr    (req_addr),
        .offchip (offchip)
    );

    emi_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_we    (req_we),
        .cfg_mux   (cfg_mux),
        .cfg_map   (map_sel),
        .cfg_width (cfg_width),
        .cfg_bank  (cfg_bank),
        .offchip   (offchip),
        .pad_dat_i (pad_dat_i),
        .req_ready (req_ready),
        .phase     (phase),
        .txn       (txn),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .int_sel   (int_sel)
    );

    emi_padmux u_pad (
        .phase (phase),
        .txn   (txn),
        .lat   (lat_pins),
        .pad   (pad_pins)
    );
endmodule

// File: rtl/emi_checker.sv
module emi_checker
    import emi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              mux_l,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              lat_ale,
    input logic              lat_rd_n,
    input logic              lat_wr_n,
    input logic [HI_W-1:0]   lat_ahi,
    input logic [DATA_W-1:0] lat_alo,
    input logic [DATA_W-1:0] lat_dat,
    input logic              lat_dat_oe,
    input logic              pad_ale_o,
    input logic              pad_rd_n_o,
    input logic              pad_wr_n_o,
    input logic [HI_W-1:0]   pad_ahi_o,
    input logic [DATA_W-1:0] pad_alo_o,
    input logic [DATA_W-1:0] pad_dat_o,
    input logic              pad_dat_oe
);
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pad_ale_o == lat_ale && pad_rd_n_o == lat_rd_n && pad_wr_n_o == lat_wr_n &&
                   pad_ahi_o == lat_ahi && pad_alo_o == lat_alo && pad_dat_o == lat_dat &&
                   pad_dat_oe == lat_dat_oe)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pad_rd_n_o || pad_wr_n_o)); // R10
    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (busy && mux_l && pad_ale_o) |=> !pad_ale_o); // R3
    AST_ALE_NONMUX: assert property (@(posedge clk) disable iff (rst)
        (busy && !mux_l) |-> (pad_ale_o == lat_ale)); // R4
    AST_READ_FLOAT: assert property (@(posedge clk) disable iff (rst)
        (busy && !pad_rd_n_o) |-> !pad_dat_oe); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done); // R3
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> ($past(busy) && !busy)); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_ready); // R9
endmodule

bind emi_ctrl emi_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (seq_busy),
    .mux_l      (cur_mux),
    .req_ready  (req_ready),
    .rsp_done   (rsp_done),
    .lat_ale    (lat_ale),
    .lat_rd_n   (lat_rd_n),
    .lat_wr_n   (lat_wr_n),
    .lat_ahi    (lat_ahi),
    .lat_alo    (lat_alo),
    .lat_dat    (lat_dat),
    .lat_dat_oe (lat_dat_oe),
    .pad_ale_o  (pad_ale_o),
    .pad_rd_n_o (pad_rd_n_o),
    .pad_wr_n_o (pad_wr_n_o),
    .pad_ahi_o  (pad_ahi_o),
    .pad_alo_o  (pad_alo_o),
    .pad_dat_o  (pad_dat_o),
    .pad_dat_oe (pad_dat_oe)
);

// File: tb/sim_emi_ctrl.sv
`timescale 1ns/1ps
module sim_emi_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_mux = 1'b0;
    logic [1:0]  cfg_map = 2'd0;
    logic [2:0]  cfg_width = 3'd0;
    logic [7:0]  cfg_bank = 8'hA5;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = 16'h0;
    logic [7:0]  req_wdata = 8'h0;
    logic        req_we = 1'b0;
    logic        req_ready, rsp_done, int_sel;
    logic [7:0]  rsp_rdata;
    localparam logic       L_ALE = 1'b1;
    localparam logic [7:0] L_AHI = 8'h3C, L_ALO = 8'hC3, L_DAT = 8'h5A;
    logic        pad_ale_o, pad_rd_n_o, pad_wr_n_o, pad_dat_oe;
    logic [7:0]  pad_ahi_o, pad_alo_o, pad_dat_o;
    logic [7:0]  pad_dat_i = 8'h00;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    emi_ctrl u0 (
        .clk(clk), .rst(rst), .cfg_mux(cfg_mux), .cfg_map(cfg_map), .cfg_width(cfg_width),
        .cfg_bank(cfg_bank), .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_we(req_we), .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .int_sel(int_sel), .lat_ale(L_ALE), .lat_rd_n(1'b1), .lat_wr_n(1'b1), .lat_ahi(L_AHI),
        .lat_alo(L_ALO), .lat_dat(L_DAT), .lat_dat_oe(1'b1), .pad_ale_o(pad_ale_o),
        .pad_rd_n_o(pad_rd_n_o), .pad_wr_n_o(pad_wr_n_o), .pad_ahi_o(pad_ahi_o),
        .pad_alo_o(pad_alo_o), .pad_dat_o(pad_dat_o), .pad_dat_oe(pad_dat_oe),
        .pad_dat_i(pad_dat_i)
    );

    typedef struct packed {
        logic        mux;
        logic [1:0]  map;
        logic [2:0]  wc;
        logic [15:0] addr;
        logic        we;
        logic [7:0]  wd;
        logic [7:0]  rd;
        logic        exp_off;
        logic [7:0]  exp_ahi;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 3'd2, 16'h8123, 1'b0, 8'h00, 8'h00, 1'b0, 8'h3C},
        '{1'b1, 2'd3, 3'd0, 16'h0234, 1'b1, 8'h9C, 8'h00, 1'b1, 8'h02},
        '{1'b1, 2'd3, 3'd3, 16'hBE11, 1'b0, 8'h00, 8'h47, 1'b1, 8'hBE},
        '{1'b0, 2'd1, 3'd1, 16'h0FFF, 1'b1, 8'h11, 8'h00, 1'b0, 8'h3C},
        '{1'b0, 2'd1, 3'd1, 16'h1000, 1'b0, 8'h00, 8'hD2, 1'b1, 8'h3C},
        '{1'b0, 2'd2, 3'd7, 16'h7F00, 1'b1, 8'h61, 8'h00, 1'b1, 8'hA5},
        '{1'b1, 2'd2, 3'd4, 16'h1001, 1'b0, 8'h00, 8'h18, 1'b1, 8'hA5},
        '{1'b0, 2'd0, 3'd0, 16'hFFFF, 1'b1, 8'h77, 8'h00, 1'b0, 8'h3C},
        '{1'b1, 2'd1, 3'd0, 16'h0FFF, 1'b0, 8'h00, 8'h00, 1'b0, 8'h3C}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic note(inout bit e, inout logic [31:0] a, inout logic [31:0] x,
                        input logic [31:0] av, input logic [31:0] xv);
        if (!e && av != xv) begin
            e = 1'b1;
            a = av;
            x = xv;
        end
    endtask

    function automatic bit pins_idle();
        return pad_ale_o == L_ALE && pad_rd_n_o && pad_wr_n_o && pad_ahi_o == L_AHI &&
               pad_alo_o == L_ALO && pad_dat_o == L_DAT && pad_dat_oe;
    endfunction

    task automatic run_vec(input vec_t v);
        int W, D, last;
        bit e_ale, e_stb, e_ahi, e_alo, e_dat, e_done, e_rdy;
        logic [31:0] a_ale, x_ale, a_stb, x_stb, a_ahi, x_ahi, a_alo, x_alo;
        logic [31:0] a_dat, x_dat, a_done, x_done, a_rdy, x_rdy;
        bit strb, own;
        {e_ale, e_stb, e_ahi, e_alo, e_dat, e_done, e_rdy} = '0;
        {a_ale, x_ale, a_stb, x_stb, a_ahi, x_ahi, a_alo, x_alo} = '0;
        {a_dat, x_dat, a_done, x_done, a_rdy, x_rdy} = '0;
        @(negedge clk);
        cfg_mux = v.mux; cfg_map = v.map; cfg_width = v.wc;
        req_addr = v.addr; req_we = v.we; req_wdata = v.wd; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (!v.exp_off) begin
            check(int_sel == 1'b1, "R2 on-chip select pulse", int_sel, 1);
            check(pins_idle() && !rsp_done, "R2 on-chip leaves pins", {pad_ahi_o, pad_dat_o}, {L_AHI, L_DAT});
            @(negedge clk);
            check(int_sel == 1'b0, "R2 select pulse one cycle", int_sel, 0);
            return;
        end
        check(int_sel == 1'b0, "R2 off-chip gives no select", int_sel, 0);
        W = int'(v.wc) + 1;
        D = v.mux ? 4 + W : 3 + W;
        last = v.mux ? 2 + W : 1 + W;
        for (int k = 1; k <= D; k++) begin
            if (k > 1) @(negedge clk);
            pad_dat_i = (k == last) ? v.rd : ~v.rd;
            own  = (k < D);
            strb = v.mux ? (k >= 3 && k <= 2 + W) : (k >= 2 && k <= 1 + W);
            note(e_done, a_done, x_done, rsp_done, k == D);
            note(e_rdy, a_rdy, x_rdy, req_ready, !own);
            if (own) begin
                note(e_ale, a_ale, x_ale, pad_ale_o, v.mux ? (k == 1) : L_ALE);
                note(e_stb, a_stb, x_stb, {pad_rd_n_o, pad_wr_n_o},
                     {!(strb && !v.we), !(strb && v.we)});
                note(e_ahi, a_ahi, x_ahi, pad_ahi_o, v.exp_ahi);
                note(e_alo, a_alo, x_alo, pad_alo_o, v.mux ? L_ALO : v.addr[7:0]);
                if (v.mux && k <= 2)
                    note(e_dat, a_dat, x_dat, {pad_dat_oe, pad_dat_o}, {1'b1, v.addr[7:0]});
                else if (v.we)
                    note(e_dat, a_dat, x_dat, {pad_dat_oe, pad_dat_o}, {1'b1, v.wd});
                else
                    note(e_dat, a_dat, x_dat, pad_dat_oe, 0);
            end else begin
                note(e_stb, a_stb, x_stb, pins_idle(), 1);
            end
        end
        check(!e_ale, v.mux ? "R3 latch-enable pattern" : "R4 latch-enable follows latch", a_ale, x_ale);
        check(!e_stb, "R10 strobe pins and release", a_stb, x_stb);
        check(!e_ahi, "R7 upper address", a_ahi, x_ahi);
        check(!e_alo, "R6 low address", a_alo, x_alo);
        check(!e_dat, "R5 data pins", a_dat, x_dat);
        check(!e_done, v.mux ? "R3 done timing" : "R4 done timing", a_done, x_done);
        check(!e_rdy, "R9 ready while busy", a_rdy, x_rdy);
        if (!v.we) check(rsp_rdata == v.rd, "R8 read capture on last strobe", rsp_rdata, v.rd);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(pins_idle(), "R1 pins follow latches in reset", {pad_ahi_o, pad_dat_o}, {L_AHI, L_DAT});
        check(!rsp_done && !int_sel && req_ready && rsp_rdata == 8'h00, "R1 reset outputs",
              {rsp_done, int_sel, req_ready, rsp_rdata}, {3'b001, 8'h00});
        rst = 1'b0;
        @(negedge clk);
        check(pins_idle(), "R1 idle pins after reset", {pad_ahi_o, pad_dat_o}, {L_AHI, L_DAT});

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);
        check(rsp_rdata == 8'h18, "R8 read data held", rsp_rdata, 8'h18);

        // R9: back-to-back, second request held valid during the first access
        @(negedge clk);
        cfg_mux = 1'b1; cfg_map = 2'd3; cfg_width = 3'd1;
        req_addr = 16'h4455; req_we = 1'b1; req_wdata = 8'h3E; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_addr = 16'h6677; req_we = 1'b0;
        pad_dat_i = 8'hE7;
        check(!req_ready, "R9 not ready after accept", req_ready, 0);
        @(negedge clk);
        check(pad_dat_o == 8'h55 && pad_dat_oe, "R9 first access keeps pins", pad_dat_o, 8'h55);
        repeat (4) @(negedge clk);
        check(rsp_done && req_ready, "R9 done and ready together", {rsp_done, req_ready}, 2'b11);
        @(negedge clk);
        req_valid = 1'b0;
        check(pad_ale_o && pad_dat_o == 8'h77, "R9 next access starts at once",
              {pad_ale_o, pad_dat_o}, {1'b1, 8'h77});
        repeat (5) @(negedge clk);
        check(rsp_done && rsp_rdata == 8'hE7, "R8 second access read", {rsp_done, rsp_rdata}, {1'b1, 8'hE7});

        // R11: configuration changed after acceptance
        @(negedge clk);
        cfg_mux = 1'b0; cfg_map = 2'd3; cfg_width = 3'd0;
        req_addr = 16'h2233; req_we = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_mux = 1'b1; cfg_width = 3'd7; cfg_map = 2'd2;
        check(pad_rd_n_o && pad_ahi_o == 8'h22, "R11 setup cycle unchanged",
              {pad_rd_n_o, pad_ahi_o}, {1'b1, 8'h22});
        @(negedge clk);
        check(!pad_rd_n_o && pad_ale_o == L_ALE && pad_alo_o == 8'h33, "R11 strobe uses sampled mode",
              {pad_rd_n_o, pad_ale_o, pad_alo_o}, {1'b0, L_ALE, 8'h33});
        @(negedge clk);
        check(pad_rd_n_o && !rsp_done, "R11 sampled width one cycle", {pad_rd_n_o, rsp_done}, 2'b10);
        @(negedge clk);
        check(rsp_done, "R11 done at sampled timing", rsp_done, 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule